// File: doc/BRIEF.md
# DRAM Low-Power Mode Sequencer

This block sits beside the command scheduler of a DRAM controller and moves the attached memory into and out of its power-down states. It owns the memory CKE line and the enable of the memory clock gate. A requested mode code chooses the target state. A static flag tells the block whether the attached device is a mobile part, and only a mobile part may have its clock stopped.

While the memory is powered down, the block watches a refresh-request line. When a refresh is needed, it wakes the memory by restarting the clock if it was stopped and then raising CKE. It hands the bus to the refresh engine with a grant, waits for the engine's done pulse, and then puts the memory back to sleep. Mode changes that arrive during such a wake-up wait until the memory is back in power-down. Every exit to the awake state is followed by an enforced quiet interval before any new entry.

Top module: `dram_lp_sequencer`

## Requirements
- R1: While reset is asserted and after it is released with no request, CKE is high, the memory clock is enabled, the grant is low and the reported mode is 0.
- R2: Mode codes are 0 = awake, 1 = power-down, 2 = power-down with clock stop. Codes 3 to 7 are deeper modes that this block does not support, and they act as code 0. They never cause an entry, and the reported mode never exceeds 2.
- R3: From awake, with the quiet interval expired and no refresh request, code 2 on a mobile device drops CKE on the next edge with the clock still running. The clock is stopped one edge later, and the reported mode is 2.
- R4: Code 2 on a non-mobile device enters plain power-down (reported mode 1) and the clock keeps running. The memory clock is disabled only while the reported mode is 2 and the device is mobile.
- R5: Code 1 drops CKE on the next edge with the clock running. A request that differs from the current mode raises CKE on the next edge, and the reported mode returns to 0.
- R6: Leaving the clock-stopped state enables the clock on the first edge and raises CKE on the second edge. CKE is never high while the clock is disabled.
- R7: A refresh request in power-down raises CKE on the next edge, or on the second edge if the clock was stopped. The grant rises one edge after CKE, so CKE has been high for at least one full cycle when the grant appears.
- R8: The grant stays high until a done pulse is sampled. On the next edge, CKE and the grant go low. In clock-stop mode, the clock is stopped again one edge after that. The reported mode is unchanged throughout the refresh.
- R9: A mode change requested while a refresh wake-up is in progress does not take effect until the memory has returned to power-down. It then exits on the following edge.
- R10: After an exit, the reported mode stays 0 for at least 16 cycles. If a new entry is requested throughout, it takes effect on the 16th edge after the exit edge.
- R11: The reported mode never changes directly from one low-power mode to another; it always passes through 0.
- R12: While awake, a refresh request produces no grant and leaves CKE and the clock enable unchanged, and a pending request blocks entry.
- R13: When a refresh request and an exit request arrive in the same cycle, the refresh is served first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_req_i | input | 3 | Requested low-power mode code |
| mobile_i | input | 1 | Attached device is a mobile type (clock stop allowed) |
| ref_req_i | input | 1 | Refresh needed |
| ref_done_i | input | 1 | Refresh engine finished (one-cycle pulse) |
| cke_o | output | 1 | Memory clock-enable (CKE) |
| mclk_en_o | output | 1 | Memory clock gate enable, 1 = clock running |
| ref_grant_o | output | 1 | Refresh engine may issue its refresh |
| lp_mode_o | output | 3 | Low-power mode currently applied, 0 when awake |

## Verification
The bench measures the quiet interval edge by edge after an exit. A counter that is off by one, or that is not restarted, would let CKE fall on the 15th or 17th edge or re-enter immediately. It drives a refresh request and an exit request together in clock-stop mode, and changes the mode while a grant is open. A design with the wrong priority or without deferral would drop CKE during the grant or jump straight to awake. Random traffic then checks the ordering rules every cycle: CKE rising only after the clock runs, the clock stopping only after CKE is low, no gating on non-mobile devices, and no direct mode-to-mode transition.

// File: rtl/lpseq_pkg.sv
`timescale 1ns/1ps
package lpseq_pkg;
  localparam int unsigned MODE_W = 3;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_NONE = mode_t'(0);
  localparam mode_t MODE_PD   = mode_t'(1);
  localparam mode_t MODE_PDG  = mode_t'(2);

  typedef enum logic [2:0] {
    ST_AWAKE    = 3'd0,
    ST_PD       = 3'd1,
    ST_CKEOFF   = 3'd2,
    ST_PDG      = 3'd3,
    ST_UNG_REF  = 3'd4,
    ST_UNG_EXIT = 3'd5,
    ST_WAKE     = 3'd6,
    ST_GRANT    = 3'd7
  } lp_state_e;
endpackage

// File: rtl/lpseq_rst_sync.sv
`timescale 1ns/1ps
module lpseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/lpseq_mode_decode.sv
`timescale 1ns/1ps
module lpseq_mode_decode
  import lpseq_pkg::*;
(
  input  mode_t mode_req_i,
  input  logic  mobile_i,
  output mode_t eff_mode_o
);
  // Unsupported codes fold to awake; clock stop folds to plain
  // power-down when the device may not lose its clock.
  always_comb begin
    unique case (mode_req_i)
      MODE_PD:  eff_mode_o = MODE_PD;
      MODE_PDG: eff_mode_o = mobile_i ? MODE_PDG : MODE_PD;
      default:  eff_mode_o = MODE_NONE;
    endcase
  end
endmodule

// File: rtl/lpseq_gap_timer.sv
`timescale 1ns/1ps
module lpseq_gap_timer #(
  parameter int unsigned GAP_CYCLES = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(GAP_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired_o = (cnt_q == '0);
  assign cnt_en    = load_i | ~expired_o;

  always_comb begin
    if (load_i) begin
      cnt_d = CW'(GAP_CYCLES);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/lpseq_fsm.sv
`timescale 1ns/1ps
module lpseq_fsm
  import lpseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t eff_mode_i,
  input  logic  ref_req_i,
  input  logic  ref_done_i,
  input  logic  gap_expired_i,
  output logic  exit_done_o,
  output logic  cke_o,
  output logic  mclk_en_o,
  output logic  ref_grant_o,
  output mode_t lp_mode_o
);
  lp_state_e state_q, state_d;
  mode_t     mode_q, mode_d;
  logic      mode_en;
  logic      cke_d, mclk_en_d, grant_d;

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    mode_d      = mode_q;
    exit_done_o = 1'b0;
    unique case (state_q)
      ST_AWAKE: begin
        if (gap_expired_i && !ref_req_i && (eff_mode_i != MODE_NONE)) begin
          mode_d  = eff_mode_i;
          state_d = (eff_mode_i == MODE_PDG) ? ST_CKEOFF : ST_PD;
        end
      end
      ST_PD: begin
        if (ref_req_i) begin
          state_d = ST_WAKE;
        end else if (eff_mode_i != mode_q) begin
          state_d     = ST_AWAKE;
          mode_d      = MODE_NONE;
          exit_done_o = 1'b1;
        end
      end
      ST_CKEOFF: state_d = ST_PDG;
      ST_PDG: begin
        if (ref_req_i) begin
          state_d = ST_UNG_REF;
        end else if (eff_mode_i != mode_q) begin
          state_d = ST_UNG_EXIT;
        end
      end
      ST_UNG_REF: state_d = ST_WAKE;
      ST_UNG_EXIT: begin
        state_d     = ST_AWAKE;
        mode_d      = MODE_NONE;
        exit_done_o = 1'b1;
      end
      ST_WAKE: state_d = ST_GRANT;
      ST_GRANT: begin
        if (ref_done_i) begin
          state_d = (mode_q == MODE_PDG) ? ST_CKEOFF : ST_PD;
        end
      end
      default: begin
        state_d = ST_AWAKE;
        mode_d  = MODE_NONE;
      end
    endcase
  end

  // Output decode from the next state, so pins come straight from flops
  always_comb begin
    cke_d     = (state_d == ST_AWAKE) || (state_d == ST_WAKE) || (state_d == ST_GRANT);
    mclk_en_d = (state_d != ST_PDG);
    grant_d   = (state_d == ST_GRANT);
  end

  assign mode_en = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_AWAKE;
      cke_o       <= 1'b1;
      mclk_en_o   <= 1'b1;
      ref_grant_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      cke_o       <= cke_d;
      mclk_en_o   <= mclk_en_d;
      ref_grant_o <= grant_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NONE;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign lp_mode_o = mode_q;
endmodule

// File: rtl/dram_lp_sequencer.sv
`timescale 1ns/1ps
module dram_lp_sequencer
  import lpseq_pkg::*;
#(
  parameter int unsigned GAP_CYCLES  = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_req_i,
  input  logic              mobile_i,
  input  logic              ref_req_i,
  input  logic              ref_done_i,
  output logic              cke_o,
  output logic              mclk_en_o,
  output logic              ref_grant_o,
  output logic [MODE_W-1:0] lp_mode_o
);
  logic  rst_core_n;
  mode_t eff_mode;
  logic  gap_expired;
  logic  exit_done;

  lpseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_core_n)
  );

  lpseq_mode_decode u_decode (
    .mode_req_i (mode_req_i),
    .mobile_i   (mobile_i),
    .eff_mode_o (eff_mode)
  );

  lpseq_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load_i    (exit_done),
    .expired_o (gap_expired)
  );

  lpseq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .eff_mode_i    (eff_mode),
    .ref_req_i     (ref_req_i),
    .ref_done_i    (ref_done_i),
    .gap_expired_i (gap_expired),
    .exit_done_o   (exit_done),
    .cke_o         (cke_o),
    .mclk_en_o     (mclk_en_o),
    .ref_grant_o   (ref_grant_o),
    .lp_mode_o     (lp_mode_o)
  );
endmodule

// File: rtl/lpseq_checker.sv
`timescale 1ns/1ps
module lpseq_checker
  import lpseq_pkg::*;
#(
  parameter int unsigned GAP_CYCLES = 15
) (
  input logic  clk,
  input logic  rst_n,
  input logic  mobile_i,
  input logic  ref_done_i,
  input logic  cke_o,
  input logic  mclk_en_o,
  input logic  ref_grant_o,
  input mode_t lp_mode_o
);
  localparam int unsigned LIM = GAP_CYCLES + 1;
  localparam int unsigned AW  = $clog2(LIM + 1);

  logic [AW-1:0] awake_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awake_cnt <= AW'(LIM);
    end else if (lp_mode_o != MODE_NONE) begin
      awake_cnt <= '0;
    end else if (awake_cnt != AW'(LIM)) begin
      awake_cnt <= awake_cnt + 1'b1;
    end
  end

  assert_gap_before_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode_o != MODE_NONE && $past(lp_mode_o) == MODE_NONE) |-> (awake_cnt >= AW'(LIM)));

  assert_cke_low_when_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en_o |-> !cke_o);

  assert_clock_before_cke_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> $past(mclk_en_o));

  assert_cke_before_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mclk_en_o) |-> $past(!cke_o));

  assert_gate_only_mode2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en_o |-> (lp_mode_o == MODE_PDG));

  assert_gate_needs_mobile_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode_o == MODE_PDG && $past(lp_mode_o) != MODE_PDG) |-> $past(mobile_i));

  assert_grant_after_cke_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant_o |-> (cke_o && $past(cke_o)));

  assert_grant_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_grant_o && !ref_done_i) |=> ref_grant_o);

  assert_sleep_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_grant_o && ref_done_i) |=> (!cke_o && !ref_grant_o));

  assert_mode_stable_in_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant_o |-> $stable(lp_mode_o));

  assert_no_direct_switch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode_o != $past(lp_mode_o)) |-> (lp_mode_o == MODE_NONE || $past(lp_mode_o) == MODE_NONE));

  assert_mode_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lp_mode_o <= MODE_PDG);

  assert_no_grant_awake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode_o == MODE_NONE) |-> !ref_grant_o);
endmodule

bind dram_lp_sequencer lpseq_checker #(.GAP_CYCLES(GAP_CYCLES)) u_lpseq_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .mobile_i    (mobile_i),
  .ref_done_i  (ref_done_i),
  .cke_o       (cke_o),
  .mclk_en_o   (mclk_en_o),
  .ref_grant_o (ref_grant_o),
  .lp_mode_o   (lp_mode_o)
);

// File: tb/dram_lp_sequencer_test.sv
`timescale 1ns/1ps
module dram_lp_sequencer_test;
  logic       clk;
  logic       rst_n;
  logic [2:0] mode_req;
  logic       mobile;
  logic       ref_req;
  logic       ref_done;
  logic       cke;
  logic       clk_en;
  logic       grant;
  logic [2:0] lp_mode;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;
  int cyc = 0;

  dram_lp_sequencer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_req_i  (mode_req),
    .mobile_i    (mobile),
    .ref_req_i   (ref_req),
    .ref_done_i  (ref_done),
    .cke_o       (cke),
    .mclk_en_o   (clk_en),
    .ref_grant_o (grant),
    .lp_mode_o   (lp_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int gap_ok(input int awake_samples);
    return (awake_samples >= 16) ? 1 : 0;
  endfunction

  function automatic int pick_mode(input int r);
    return (r < 6) ? (r % 3) : r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done_flag) begin
      done_flag = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int n;
    int awake_n;
    logic p_cke, p_clk, p_grant, d_done;
    logic [2:0] p_lp;

    void'($urandom(32'h5EED_1234));
    rst_n    = 1'b0;
    mode_req = 3'd0;
    mobile   = 1'b1;
    ref_req  = 1'b0;
    ref_done = 1'b0;

    // R1: reset state
    repeat (3) tick();
    chk("R1 cke in reset", cke, 1);
    chk("R1 clk_en in reset", clk_en, 1);
    chk("R1 grant in reset", grant, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 cke after reset", cke, 1);
    chk("R1 lp_mode after reset", lp_mode, 0);

    // R12: refresh request while awake is ignored and blocks entry
    ref_req = 1'b1;
    repeat (3) tick();
    chk("R12 no grant awake", grant, 0);
    chk("R12 cke awake", cke, 1);
    mode_req = 3'd1;
    tick();
    chk("R12 entry blocked", cke, 1);
    ref_req = 1'b0;
    tick();
    chk("R5 enter pd cke", cke, 0);
    chk("R5 enter pd clk", clk_en, 1);
    chk("R5 enter pd mode", lp_mode, 1);

    // R7: refresh wake from plain power-down
    ref_req = 1'b1;
    tick();
    chk("R7 cke wake", cke, 1);
    chk("R7 no grant yet", grant, 0);
    tick();
    chk("R7 grant", grant, 1);
    ref_req = 1'b0;
    tick();
    chk("R8 grant held", grant, 1);
    mode_req = 3'd0;  // R9: exit request during refresh
    tick();
    chk("R9 still granted", grant, 1);
    chk("R9 mode kept", lp_mode, 1);
    ref_done = 1'b1;
    tick();
    ref_done = 1'b0;
    chk("R8 cke low after done", cke, 0);
    chk("R8 grant low after done", grant, 0);
    chk("R9 mode kept after done", lp_mode, 1);
    tick();
    chk("R9 deferred exit cke", cke, 1);
    chk("R5 exit mode", lp_mode, 0);

    // R10: quiet interval, then R3 entry into clock stop
    mode_req = 3'd2;
    n = 0;
    do begin
      tick();
      n++;
    end while (cke == 1'b1 && n < 40);
    chk("R10 edges to re-entry", n, 16);
    chk("R3 clk still on", clk_en, 1);
    chk("R3 mode 2", lp_mode, 2);
    tick();
    chk("R3 clk gated", clk_en, 0);

    // R7: refresh wake from clock stop
    ref_req = 1'b1;
    tick();
    chk("R7 ungate first clk", clk_en, 1);
    chk("R7 ungate first cke", cke, 0);
    tick();
    chk("R7 cke after ungate", cke, 1);
    tick();
    chk("R7 grant gated mode", grant, 1);
    ref_req = 1'b0;
    ref_done = 1'b1;
    tick();
    ref_done = 1'b0;
    chk("R8 cke low gated", cke, 0);
    chk("R8 clk on one cycle", clk_en, 1);
    tick();
    chk("R8 clk regated", clk_en, 0);
    chk("R8 mode kept", lp_mode, 2);

    // R13: refresh and exit requested together
    mode_req = 3'd0;
    ref_req  = 1'b1;
    tick();
    chk("R13 clk on", clk_en, 1);
    tick();
    tick();
    chk("R13 refresh served", grant, 1);
    chk("R13 mode kept", lp_mode, 2);
    ref_req  = 1'b0;
    ref_done = 1'b1;
    tick();
    ref_done = 1'b0;
    chk("R8 back down", cke, 0);
    tick();
    chk("R8 regated before exit", clk_en, 0);
    tick();
    chk("R6 exit clk first", clk_en, 1);
    chk("R6 exit cke still low", cke, 0);
    tick();
    chk("R6 exit cke", cke, 1);
    chk("R6 exit mode", lp_mode, 0);

    // R4: non-mobile device never gates the clock
    mobile = 1'b0;
    repeat (20) tick();
    mode_req = 3'd2;
    tick();
    chk("R4 cke low", cke, 0);
    chk("R4 mode 1", lp_mode, 1);
    tick();
    chk("R4 clk kept", clk_en, 1);
    mode_req = 3'd3;  // R2: unsupported code acts as awake
    tick();
    chk("R2 code 3 exits", cke, 1);
    chk("R2 code 3 mode", lp_mode, 0);
    repeat (20) tick();
    chk("R2 code 3 no entry", lp_mode, 0);
    chk("R2 code 3 cke", cke, 1);

    // Random phase with per-cycle rule checks
    awake_n = 20;
    p_cke = cke; p_clk = clk_en; p_grant = grant; p_lp = lp_mode;
    for (int i = 0; i < 6000; i++) begin
      if (lp_mode == 3'd0 && ($urandom % 500) == 0) mobile = ~mobile;
      if (($urandom % 16) == 0) mode_req = 3'(pick_mode(int'($urandom % 8)));
      if (grant) ref_req = 1'b0;
      else if (!ref_req && ($urandom % 24) == 0) ref_req = 1'b1;
      else if (ref_req && lp_mode == 3'd0 && ($urandom % 4) == 0) ref_req = 1'b0;
      ref_done = grant && (($urandom % 3) == 0);
      d_done = ref_done;
      tick();
      if (!clk_en) begin
        chk("R6 cke low while gated", cke, 0);
        chk("R4 gated only mobile mode 2", (lp_mode == 3'd2 && mobile) ? 1 : 0, 1);
      end
      if (cke && !p_cke) chk("R6 clk before cke", p_clk, 1);
      if (!clk_en && p_clk) chk("R3 cke before gate", p_cke, 0);
      if (grant) chk("R7 cke before grant", (p_cke && cke) ? 1 : 0, 1);
      if (p_grant && !d_done) chk("R8 grant held", grant, 1);
      if (p_grant && d_done) chk("R8 release", (cke || grant) ? 1 : 0, 0);
      if (lp_mode != p_lp) chk("R11 via awake", (lp_mode == 0 || p_lp == 0) ? 1 : 0, 1);
      if (lp_mode != 0 && p_lp == 0) chk("R10 gap kept", gap_ok(awake_n), 1);
      if (p_lp == 0 && lp_mode == 0) chk("R12 no grant awake", grant, 0);
      chk("R2 mode range", (lp_mode <= 3'd2) ? 1 : 0, 1);
      if (lp_mode == 0) awake_n++;
      else awake_n = 0;
      p_cke = cke; p_clk = clk_en; p_grant = grant; p_lp = lp_mode;
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule